// File: doc/BRIEF.md
# Outbound Window Address Translator

This block turns a 32-bit local slave address into a 64-bit system bus address. The address is split at a fixed pass-through boundary. The bits below the boundary go straight to the output. A few bits just above the boundary pick one entry of a small table that software can program. The chosen entry supplies every output bit above the boundary, along with a 2-bit code that says which address space the access targets.

The top local bits, above the index field, belong to the slave's own base decode and have no effect on the result. A lookup request is taken with a valid strobe. The translated address and the space code come back one cycle later, marked by their own valid flag.

Software fills the table through a separate 32-bit register port. Each entry takes two words on that port: a low word and a high word. Reads on the register port return their data one cycle after the read strobe.

Top module: `aot_xlate`

## Requirements
- R1: When `xl_valid` is high, `xl_addr[11:0]` equals `req_addr[11:0]` of the request that was accepted one cycle earlier.
- R2: `req_addr[15:12]` selects one of 16 entries. `xl_addr[63:12]` equals the 52-bit upper address stored in that entry.
- R3: `req_addr[31:16]` has no effect on `xl_addr` or `xl_space`.
- R4: `xl_space` carries the 2-bit space code of the selected entry unchanged, including the value 11. The codes are 00 for 32-bit memory, 01 for 64-bit memory, 10 for I/O and 11 reserved.
- R5: `xl_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R6: After reset every entry holds upper address 0 and space code 00, and both `xl_valid` and `cfg_rvalid` are low.
- R7: The register port uses a byte address. Entry i has its low word at byte address i*8 and its high word at i*8+4, so `cfg_addr[6:3]` is the index and `cfg_addr[2]` selects the high word. The low word holds the space code in bits 1:0 and address bits 31:12 in bits 31:12. The high word holds address bits 63:32. A write to either word replaces only the fields that word holds.
- R8: `cfg_rvalid` is high exactly one cycle after `cfg_rd`, and in that cycle `cfg_rdata` holds the addressed word.
- R9: A lookup of an entry in the same cycle as a register write to that entry returns the old contents. The new contents apply from the following cycle.
- R10: Low-word bits 11:2 are not stored. They always read back as zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Local address to translate |
| xl_valid | output | 1 | Translated result valid |
| xl_addr | output | 64 | Translated address |
| xl_space | output | 2 | Space code of the selected entry |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 7 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |

## Verification
The assertions assume that `req_valid`, `cfg_rd` and the request address are known at every clock edge. They also assume that `cfg_addr[1:0]` is zero, because the port only decodes word-aligned addresses. The bench changes every input on the falling edge, so each value is settled before the rising edge that uses it. It uses only word-aligned register addresses. It never raises `cfg_rd` and `cfg_wr` together, so the read-back data never depends on the order of a read and a write to the same word.

// File: rtl/aot_pkg.sv
package aot_pkg;

    localparam int LOC_AW   = 32;                 // local address width
    localparam int PASS_W   = 12;                 // pass-through bits
    localparam int IDX_TOP  = 16;                 // first bit above the index field
    localparam int OUT_AW   = 64;                 // output address width
    localparam int REG_W    = 32;                 // register port width

    localparam int IDX_W    = IDX_TOP - PASS_W;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int HI_W     = OUT_AW - PASS_W;    // stored upper address width
    localparam int LO_PART  = REG_W - PASS_W;     // upper bits held in the low word
    localparam int HW_PART  = HI_W - LO_PART;     // upper bits held in the high word
    localparam int CFG_AW   = IDX_W + 3;

    typedef enum logic [1:0] {
        SP_MEM32 = 2'b00,
        SP_MEM64 = 2'b01,
        SP_IO    = 2'b10,
        SP_RSVD  = 2'b11
    } aot_space_e;

    typedef struct packed {
        aot_space_e       space;
        logic [HI_W-1:0]  hi;
    } aot_entry_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hi_word;
    } aot_cfg_sel_t;

    function automatic aot_cfg_sel_t cfg_decode(input logic [CFG_AW-1:0] a);
        aot_cfg_sel_t s;
        s.idx     = a[CFG_AW-1:3];
        s.hi_word = a[2];
        return s;
    endfunction

    function automatic logic [REG_W-1:0] low_word(input aot_entry_t e);
        return {e.hi[LO_PART-1:0], {(PASS_W-2){1'b0}}, e.space};
    endfunction

    function automatic logic [REG_W-1:0] high_word(input aot_entry_t e);
        return e.hi[HI_W-1:LO_PART];
    endfunction

endpackage

// File: rtl/aot_entry_bank.sv
module aot_entry_bank
    import aot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CFG_AW-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output aot_entry_t         tbl [ENTRIES]
);
    aot_cfg_sel_t sel;
    assign sel = cfg_decode(wr_addr);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (sel.idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g].hi    <= '0;
                tbl[g].space <= SP_MEM32;
            end else if (hit) begin
                if (sel.hi_word) begin
                    tbl[g].hi[HI_W-1:LO_PART] <= wr_data[HW_PART-1:0];
                end else begin
                    tbl[g].hi[LO_PART-1:0] <= wr_data[REG_W-1:PASS_W];
                    tbl[g].space           <= aot_space_e'(wr_data[1:0]);
                end
            end
        end
    end
endmodule

// File: rtl/aot_lookup.sv
module aot_lookup
    import aot_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [IDX_TOP-1:0]  req_lo,
    input  aot_entry_t          tbl [ENTRIES],
    output logic                xl_valid,
    output logic [OUT_AW-1:0]   xl_addr,
    output logic [1:0]          xl_space
);
    logic [IDX_W-1:0] idx;
    aot_entry_t       pick;

    assign idx  = req_lo[IDX_TOP-1:PASS_W];
    assign pick = tbl[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_valid <= 1'b0;
            xl_addr  <= '0;
            xl_space <= SP_MEM32;
        end else begin
            xl_valid <= req_valid;
            if (req_valid) begin
                xl_addr  <= {pick.hi, req_lo[PASS_W-1:0]};
                xl_space <= pick.space;
            end
        end
    end
endmodule

// File: rtl/aot_cfg_read.sv
module aot_cfg_read
    import aot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [CFG_AW-1:0]  rd_addr,
    input  aot_entry_t         tbl [ENTRIES],
    output logic               rvalid,
    output logic [REG_W-1:0]   rdata
);
    aot_cfg_sel_t sel;
    aot_entry_t   e;
    logic [REG_W-1:0] word;

    assign sel  = cfg_decode(rd_addr);
    assign e    = tbl[sel.idx];
    assign word = sel.hi_word ? high_word(e) : low_word(e);

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= word;
        end
    end
endmodule

// File: rtl/aot_xlate.sv
module aot_xlate
    import aot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [LOC_AW-1:0]    req_addr,
    output logic                 xl_valid,
    output logic [OUT_AW-1:0]    xl_addr,
    output logic [1:0]           xl_space,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic                 cfg_rvalid,
    output logic [REG_W-1:0]     cfg_rdata
);
    aot_entry_t tbl [ENTRIES];

    aot_entry_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .tbl     (tbl)
    );

    aot_lookup u_lookup (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_lo    (req_addr[IDX_TOP-1:0]),
        .tbl       (tbl),
        .xl_valid  (xl_valid),
        .xl_addr   (xl_addr),
        .xl_space  (xl_space)
    );

    aot_cfg_read u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (cfg_rd),
        .rd_addr (cfg_addr),
        .tbl     (tbl),
        .rvalid  (cfg_rvalid),
        .rdata   (cfg_rdata)
    );
endmodule

// File: rtl/aot_xlate_chk.sv
module aot_xlate_chk
    import aot_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [LOC_AW-1:0]  req_addr,
    input logic               xl_valid,
    input logic [OUT_AW-1:0]  xl_addr,
    input logic               cfg_rd,
    input logic [CFG_AW-1:0]  cfg_addr,
    input logic               cfg_rvalid,
    input logic [REG_W-1:0]   cfg_rdata
);
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        xl_valid |-> xl_addr[PASS_W-1:0] == $past(req_addr[PASS_W-1:0])); // R1
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> xl_valid); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !xl_valid); // R5
    AST_RD_ACK: assert property (@(posedge clk) disable iff (rst)
        cfg_rd |=> cfg_rvalid); // R8
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> !cfg_rvalid); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && !$past(cfg_addr[2])) |-> cfg_rdata[PASS_W-1:2] == '0); // R10
endmodule

bind aot_xlate aot_xlate_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .xl_valid   (xl_valid),
    .xl_addr    (xl_addr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/aot_xlate_tb_top.sv
module aot_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        xl_valid;
    logic [63:0] xl_addr;
    logic [1:0]  xl_space;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [51:0] m_hi [16];
    logic [1:0]  m_sp [16];

    always #2 clk = ~clk;

    aot_xlate dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input bit hw, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = {idx[3:0], hw, 2'b00}; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (hw) m_hi[idx][51:20] = d;
        else begin m_hi[idx][19:0] = d[31:12]; m_sp[idx] = d[1:0]; end
    endtask

    task automatic cfg_read(input int idx, input bit hw, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = {idx[3:0], hw, 2'b00};
        @(posedge clk); #1;
        check(cfg_rvalid === 1'b1, "R8 rvalid", 64'(cfg_rvalid), 64'd1);
        d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic lookup_chk(input logic [31:0] a, input string tag);
        int i;
        i = int'(a[15:12]);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); #1;
        check(xl_valid === 1'b1, {tag, " R5 valid"}, 64'(xl_valid), 64'd1);
        check(xl_addr === {m_hi[i], a[11:0]}, {tag, " R1 R2 addr"}, xl_addr, {m_hi[i], a[11:0]});
        check(xl_space === m_sp[i], {tag, " R4 space"}, 64'(xl_space), 64'(m_sp[i]));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(xl_valid === 1'b0 && cfg_rvalid === 1'b0, "R6 outputs idle", {xl_valid, cfg_rvalid}, 64'd0);
        lookup_chk(32'h0000_9ABC, "R6 zero table");
        cfg_read(9, 1'b0, d); check(d === 32'h0, "R6 low word", d, 0);
        cfg_read(9, 1'b1, d); check(d === 32'h0, "R6 high word", d, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        cfg_write(3, 1'b0, 32'hABCDE_001);
        cfg_write(3, 1'b1, 32'h1234_5678);
        cfg_write(15, 1'b0, 32'hFFFFF_003);
        cfg_write(15, 1'b1, 32'hDEAD_BEEF);
        cfg_write(0, 1'b1, 32'h0000_0001);
        cfg_write(7, 1'b0, 32'h00001_002);
        cfg_read(3, 1'b0, d);  check(d === 32'hABCDE_001, "R7 e3 low", d, 32'hABCDE_001);
        cfg_read(3, 1'b1, d);  check(d === 32'h1234_5678, "R7 e3 high", d, 32'h1234_5678);
        cfg_read(15, 1'b1, d); check(d === 32'hDEAD_BEEF, "R7 e15 high", d, 32'hDEAD_BEEF);
        cfg_write(3, 1'b1, 32'h5555_AAAA);
        cfg_read(3, 1'b0, d);  check(d === 32'hABCDE_001, "R7 high write keeps low", d, 32'hABCDE_001);
    endtask

    task automatic t_rsvd;
        logic [31:0] d;
        cfg_write(5, 1'b0, 32'h13579_FFE);
        cfg_read(5, 1'b0, d);
        check(d === 32'h13579_002, "R10 bits 11:2 zero", d, 32'h13579_002);
    endtask

    task automatic t_lookups;
        lookup_chk(32'h0000_3FFF, "e3");
        lookup_chk(32'h0000_F000, "e15");
        lookup_chk(32'h0000_0123, "e0");
        lookup_chk(32'h0000_7ABC, "e7");
        lookup_chk(32'h0000_5001, "e5");
    endtask

    task automatic t_base;
        logic [63:0] a0; logic [1:0] s0;
        lookup_chk(32'h0000_F456, "R3 base 0000");
        a0 = xl_addr; s0 = xl_space;
        lookup_chk(32'hC3A5_F456, "R3 base C3A5");
        check(xl_addr === a0 && xl_space === s0, "R3 upper ignored", xl_addr, a0);
    endtask

    task automatic t_valid_gap;
        @(negedge clk); req_valid = 1'b1; req_addr = 32'h0000_3000;
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check(xl_valid === 1'b0, "R5 drops after idle", 64'(xl_valid), 64'd0);
    endtask

    task automatic t_collide;
        logic [51:0] old_hi;
        old_hi = m_hi[3];
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = {4'd3, 1'b1, 2'b00}; cfg_wdata = 32'h0BAD_F00D;
        req_valid = 1'b1; req_addr = 32'h0000_3010;
        @(posedge clk); #1;
        check(xl_addr === {old_hi, 12'h010}, "R9 old contents", xl_addr, {old_hi, 12'h010});
        @(negedge clk);
        cfg_wr = 1'b0;
        m_hi[3][51:20] = 32'h0BAD_F00D;
        @(posedge clk); #1;
        check(xl_addr === {m_hi[3], 12'h010}, "R9 new contents", xl_addr, {m_hi[3], 12'h010});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_hi[i] = '0; m_sp[i] = 2'b00; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset;
        t_map;
        t_rsvd;
        t_lookups;
        t_base;
        t_valid_gap;
        t_collide;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule